// File: doc/BRIEF.md
# USB Host Root-Port Compliance Test Controller

This block lets software put one or more root ports of a USB 2.0 host into an electrical compliance test. Software drives it through a small register port. A command register holds run/stop, controller reset and the two schedule enables. A status register reports the halted state and a sticky entry-error flag. A configuration register holds the port-ownership flag. Each port has its own register with a suspend bit and a 3-bit test-control field. On the port side the block drives a 2-bit line-state code, a one-cycle start strobe for the test packet, an SOF-enable level and a test-active flag for each port.

A test is armed only when the controller is already safe: stopped and halted, the port suspended, both schedules off, and the configuration flag set. A request made at any other time is dropped and recorded in the error flag. Once a port is in a test, its register is frozen. The only way out is a controller reset issued while the controller is halted. In force-enable mode the SOF-enable output follows run/stop, so software can restart frame emission on the port under test.

Top module: `usb_ptest_ctrl`

## Requirements
- R1: After `rst` the block is stopped and halted. All line codes read 0 (idle), and every SOF-enable, packet strobe and test-active output is 0. The status register (address 1) reads halted=1 (bit 0) and error=0 (bit 1).
- R2: The halted status (output `hc_halted` and status bit 0) goes to 1 exactly 2 cycles after the edge that clears run/stop (command address 0, bit 0). It goes to 0 one cycle after the edge that sets run/stop.
- R3: A test-control value (port register at address 3+p, bits 6:4) is decoded as follows: 1 = J, 2 = K, 3 = SE0_NAK, 4 = Packet, 5 = Force_Enable. In those modes the line code is J=1, K=2, SE0=3, and 0 (idle) for Packet and Force_Enable. The field reads back the active code.
- R4: A nonzero test request is accepted only if all of these hold at the write edge: halted=1, the stored suspend bit (port bit 0) is 1, periodic enable (command bit 2) is 0, asynchronous enable (command bit 3) is 0, and the configuration flag (address 2, bit 0) is 1. Otherwise the request is ignored and the sticky error bit is set. Writing 1 to status bit 1 clears the error bit.
- R5: Test-control values 6 and 7 act as disabled. No test starts and no error is flagged.
- R6: On entry to Packet mode, `port_pkt_start` is 1 for exactly the first cycle in which the mode is active.
- R7: In Force_Enable mode, `port_sof_en` equals run/stop. In the other test modes it is 0.
- R8: While a port is in a test, writes to that port's register change neither its mode nor its suspend bit, and set no error. Run/stop changes do not end the test. Other ports are unaffected.
- R9: A controller reset request (command bit 1) is taken only while halted. When taken, the edge that takes it returns every port to idle line and no test, and clears the suspend bits, the schedule enables and the error bit. A request made while not halted is ignored.
- R10: Outside a test, `port_sof_en` is 1 when run/stop=1, the configuration flag is 1 and the port is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_raddr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data (combinational) |
| hc_halted | output | 1 | Controller halted status |
| port_line | output | 2*N_PORTS | Line-state code per port |
| port_pkt_start | output | N_PORTS | Test-packet start strobe per port |
| port_sof_en | output | N_PORTS | SOF-enable per port |
| port_test_on | output | N_PORTS | Test-active flag per port |

## Verification
A register write lands on the single clock edge it spans. Mode, suspend, error, run/stop and the port outputs derived from them change on that edge, so the bench samples them at the falling edge that ends the write. The packet strobe is checked there and again one cycle later, when it must have dropped. Halted is the one delayed result. The bench samples it at one and two cycles after the run/stop write and expects 0 then 1, and at one cycle after setting run/stop, where it must read 0. A controller reset is checked in the sample right after its write, matching the one-edge return to idle.

// File: rtl/ptest_pkg.sv
package ptest_pkg;

    // register addresses
    localparam int ADDR_CMD   = 0;
    localparam int ADDR_STS   = 1;
    localparam int ADDR_CFG   = 2;
    localparam int ADDR_PORT0 = 3;

    // field positions
    localparam int CMD_RUN     = 0;
    localparam int CMD_HCRST   = 1;
    localparam int CMD_PER     = 2;
    localparam int CMD_ASY     = 3;
    localparam int STS_HALT    = 0;
    localparam int STS_ERR     = 1;
    localparam int CFG_FLAG    = 0;
    localparam int PORT_SUSP   = 0;
    localparam int PORT_TC_LSB = 4;
    localparam int TC_W        = 3;

    typedef enum logic [TC_W-1:0] {
        TM_OFF   = 3'd0,
        TM_J     = 3'd1,
        TM_K     = 3'd2,
        TM_SE0   = 3'd3,
        TM_PKT   = 3'd4,
        TM_FORCE = 3'd5
    } tmode_e;

    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_J    = 2'd1,
        LN_K    = 2'd2,
        LN_SE0  = 2'd3
    } line_e;

    typedef struct packed {
        logic async_en;
        logic per_en;
        logic run;
    } cmd_t;

    function automatic tmode_e decode_tc(input logic [TC_W-1:0] v);
        case (v)
            3'd1:    return TM_J;
            3'd2:    return TM_K;
            3'd3:    return TM_SE0;
            3'd4:    return TM_PKT;
            3'd5:    return TM_FORCE;
            default: return TM_OFF;
        endcase
    endfunction

    function automatic line_e line_of(input tmode_e m);
        case (m)
            TM_J:    return LN_J;
            TM_K:    return LN_K;
            TM_SE0:  return LN_SE0;
            default: return LN_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/ptest_halt_timer.sv
module ptest_halt_timer #(
    parameter int HALT_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic halted
);
    localparam int CNT_W = (HALT_LAT < 2) ? 1 : $clog2(HALT_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALT_LAT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b1;
            cnt_q  <= '0;
        end else if (run) begin
            halted <= 1'b0;
            cnt_q  <= '0;
        end else if (!halted) begin
            if (cnt_q == LAST) begin
                halted <= 1'b1;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptest_hc_regs.sv
module ptest_hc_regs
    import ptest_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_we,
    input  logic sts_we,
    input  logic cfg_we,
    input  logic wr_run,
    input  logic wr_hcrst,
    input  logic wr_per,
    input  logic wr_asy,
    input  logic wr_errclr,
    input  logic wr_cfg,
    input  logic halted,
    input  logic rej_any,
    output cmd_t cmd,
    output logic cfg,
    output logic err,
    output logic rst_take
);
    assign rst_take = cmd_we && wr_hcrst && halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
            cfg <= 1'b0;
            err <= 1'b0;
        end else begin
            if (rst_take) begin
                cmd <= '0;
            end else if (cmd_we) begin
                cmd.run      <= wr_run;
                cmd.per_en   <= wr_per;
                cmd.async_en <= wr_asy;
            end

            if (cfg_we)
                cfg <= wr_cfg;

            if (rst_take)
                err <= 1'b0;
            else if (rej_any)
                err <= 1'b1;
            else if (sts_we && wr_errclr)
                err <= 1'b0;
        end
    end
endmodule

// File: rtl/ptest_port_ctl.sv
module ptest_port_ctl
    import ptest_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hc_rst,
    input  logic            wr_hit,
    input  logic            wr_susp,
    input  logic [TC_W-1:0] wr_tc,
    input  logic            halted,
    input  logic            sched_busy,
    input  logic            cfg,
    input  logic            run,
    output logic            susp,
    output tmode_e          mode,
    output line_e           line,
    output logic            pkt_start,
    output logic            sof_en,
    output logic            test_on,
    output logic            reject
);
    tmode_e req;
    logic   ready;
    logic   idle_wr;

    assign req     = decode_tc(wr_tc);
    assign ready   = halted && susp && !sched_busy && cfg;
    assign idle_wr = wr_hit && (mode == TM_OFF);
    assign reject  = idle_wr && (req != TM_OFF) && !ready;

    always_ff @(posedge clk) begin
        if (rst || hc_rst) begin
            mode      <= TM_OFF;
            susp      <= 1'b0;
            pkt_start <= 1'b0;
        end else begin
            pkt_start <= 1'b0;
            if (idle_wr) begin
                susp <= wr_susp;
                if (req != TM_OFF && ready) begin
                    mode      <= req;
                    pkt_start <= (req == TM_PKT);
                end
            end
        end
    end

    assign test_on = (mode != TM_OFF);
    assign line    = line_of(mode);

    always_comb begin
        case (mode)
            TM_OFF:   sof_en = run && cfg && !susp;
            TM_FORCE: sof_en = run;
            default:  sof_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/usb_ptest_ctrl.sv
module usb_ptest_ctrl
    import ptest_pkg::*;
#(
    parameter int N_PORTS  = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int HALT_LAT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [ADDR_W-1:0]    reg_raddr,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 hc_halted,
    output logic [2*N_PORTS-1:0] port_line,
    output logic [N_PORTS-1:0]   port_pkt_start,
    output logic [N_PORTS-1:0]   port_sof_en,
    output logic [N_PORTS-1:0]   port_test_on
);
    cmd_t   cmd;
    logic   run_q;
    logic   halted_q;
    logic   cfg_q;
    logic   err_q;
    logic   hc_rst_take;
    logic   sched_busy;
    logic   rej_any;
    logic   cmd_we, sts_we, cfg_we;
    logic   [N_PORTS-1:0] susp_v;
    logic   [N_PORTS-1:0] rej_v;
    tmode_e mode_v [N_PORTS];

    assign cmd_we     = reg_we && (reg_addr == ADDR_W'(ADDR_CMD));
    assign sts_we     = reg_we && (reg_addr == ADDR_W'(ADDR_STS));
    assign cfg_we     = reg_we && (reg_addr == ADDR_W'(ADDR_CFG));
    assign run_q      = cmd.run;
    assign sched_busy = cmd.per_en || cmd.async_en;
    assign rej_any    = |rej_v;
    assign hc_halted  = halted_q;

    ptest_hc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (cmd_we),
        .sts_we    (sts_we),
        .cfg_we    (cfg_we),
        .wr_run    (reg_wdata[CMD_RUN]),
        .wr_hcrst  (reg_wdata[CMD_HCRST]),
        .wr_per    (reg_wdata[CMD_PER]),
        .wr_asy    (reg_wdata[CMD_ASY]),
        .wr_errclr (reg_wdata[STS_ERR]),
        .wr_cfg    (reg_wdata[CFG_FLAG]),
        .halted    (halted_q),
        .rej_any   (rej_any),
        .cmd       (cmd),
        .cfg       (cfg_q),
        .err       (err_q),
        .rst_take  (hc_rst_take)
    );

    ptest_halt_timer #(.HALT_LAT(HALT_LAT)) u_halt (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .halted (halted_q)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic  hit;
        line_e ln;

        assign hit = reg_we && (reg_addr == ADDR_W'(ADDR_PORT0 + p));

        ptest_port_ctl u_port (
            .clk        (clk),
            .rst        (rst),
            .hc_rst     (hc_rst_take),
            .wr_hit     (hit),
            .wr_susp    (reg_wdata[PORT_SUSP]),
            .wr_tc      (reg_wdata[PORT_TC_LSB +: TC_W]),
            .halted     (halted_q),
            .sched_busy (sched_busy),
            .cfg        (cfg_q),
            .run        (run_q),
            .susp       (susp_v[p]),
            .mode       (mode_v[p]),
            .line       (ln),
            .pkt_start  (port_pkt_start[p]),
            .sof_en     (port_sof_en[p]),
            .test_on    (port_test_on[p]),
            .reject     (rej_v[p])
        );

        assign port_line[2*p +: 2] = ln;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == ADDR_W'(ADDR_CMD)) begin
            reg_rdata[CMD_RUN] = cmd.run;
            reg_rdata[CMD_PER] = cmd.per_en;
            reg_rdata[CMD_ASY] = cmd.async_en;
        end else if (reg_raddr == ADDR_W'(ADDR_STS)) begin
            reg_rdata[STS_HALT] = halted_q;
            reg_rdata[STS_ERR]  = err_q;
        end else if (reg_raddr == ADDR_W'(ADDR_CFG)) begin
            reg_rdata[CFG_FLAG] = cfg_q;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                if (reg_raddr == ADDR_W'(ADDR_PORT0 + p)) begin
                    reg_rdata[PORT_SUSP]             = susp_v[p];
                    reg_rdata[PORT_TC_LSB +: TC_W]   = mode_v[p];
                end
            end
        end
    end
endmodule

// File: rtl/ptest_chk.sv
module ptest_chk #(
    parameter int N_PORTS  = 2,
    parameter int HALT_LAT = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 run_q,
    input logic                 halted_q,
    input logic                 sched_busy,
    input logic                 cfg_q,
    input logic                 hc_rst_take,
    input logic [N_PORTS-1:0]   susp_v,
    input logic [N_PORTS-1:0]   port_test_on,
    input logic [N_PORTS-1:0]   port_sof_en,
    input logic [N_PORTS-1:0]   port_pkt_start,
    input logic [2*N_PORTS-1:0] port_line
);
    localparam int CW = $clog2(HALT_LAT + 1);
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= CW'(HALT_LAT);
        else if (run_q)
            low_cnt <= '0;
        else if (low_cnt != CW'(HALT_LAT))
            low_cnt <= low_cnt + 1'b1;
    end

    // R2
    halt_due_chk: assert property (@(posedge clk) disable iff (rst)
        (low_cnt == CW'(HALT_LAT)) |-> halted_q);

    // R2
    halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> !halted_q);

    // R9
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(hc_rst_take) |-> (port_line == '0 && port_test_on == '0));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
        // R4
        entry_gate_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(port_test_on[p]) |->
                $past(halted_q && susp_v[p] && !sched_busy && cfg_q));

        // R9
        exit_only_reset_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(port_test_on[p]) |-> $past(hc_rst_take || rst));

        // R7
        sof_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
            port_sof_en[p] |-> run_q);

        // R6
        pkt_single_chk: assert property (@(posedge clk) disable iff (rst)
            port_pkt_start[p] |=> !port_pkt_start[p]);

        // R6
        pkt_in_test_chk: assert property (@(posedge clk) disable iff (rst)
            port_pkt_start[p] |-> port_test_on[p]);
    end
endmodule

bind usb_ptest_ctrl ptest_chk #(.N_PORTS(N_PORTS), .HALT_LAT(HALT_LAT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .run_q          (run_q),
    .halted_q       (halted_q),
    .sched_busy     (sched_busy),
    .cfg_q          (cfg_q),
    .hc_rst_take    (hc_rst_take),
    .susp_v         (susp_v),
    .port_test_on   (port_test_on),
    .port_sof_en    (port_sof_en),
    .port_pkt_start (port_pkt_start),
    .port_line      (port_line)
);

// File: tb/sim_usb_ptest_ctrl.sv
module sim_usb_ptest_ctrl;
    localparam int NP = 2;
    localparam int AW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic          hc_halted;
    logic [2*NP-1:0] port_line;
    logic [NP-1:0] port_pkt_start, port_sof_en, port_test_on;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    usb_ptest_ctrl #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .HALT_LAT(2)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .hc_halted(hc_halted), .port_line(port_line),
        .port_pkt_start(port_pkt_start), .port_sof_en(port_sof_en),
        .port_test_on(port_test_on)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(int a, output int d);
        reg_raddr = AW'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int line(int p);
        return int'(port_line[2*p +: 2]);
    endfunction

    // controller reset (taken when halted) and arm port p for a test
    task automatic hc_reset();
        wr(0, 8'h02);
    endtask

    task automatic arm(int p);
        wr(2, 1);
        wr(3 + p, 1);
    endtask

    task automatic t_reset_state();
        int d;
        chk("R1 halted", hc_halted, 1);
        chk("R1 line", int'(port_line), 0);
        chk("R1 sof", int'(port_sof_en), 0);
        chk("R1 pkt", int'(port_pkt_start), 0);
        chk("R1 test_on", int'(port_test_on), 0);
        rd(1, d); chk("R1 status", d, 1);
    endtask

    task automatic t_halt_and_sof();
        wr(2, 1);
        wr(0, 1);
        chk("R2 halted same cycle as run set", hc_halted, 1);
        tick(1);
        chk("R2 halted drops after run set", hc_halted, 0);
        chk("R10 sof with run, cfg, unsuspended", port_sof_en[0], 1);
        wr(3, 1);
        chk("R10 sof off when suspended", port_sof_en[0], 0);
        chk("R10 other port sof", port_sof_en[1], 1);
        wr(0, 0);
        chk("R2 halted 0 right after clear", hc_halted, 0);
        tick(1);
        chk("R2 halted 0 after 1 cycle", hc_halted, 0);
        tick(1);
        chk("R2 halted 1 after 2 cycles", hc_halted, 1);
        hc_reset();
    endtask

    task automatic t_reject();
        int d;
        wr(2, 1);
        wr(3, 8'h10);
        chk("R4 unsuspended rejected", port_test_on[0], 0);
        rd(1, d); chk("R4 error set", d, 3);
        wr(1, 2);
        rd(1, d); chk("R4 error cleared by W1C", d, 1);
        wr(3, 1);
        wr(0, 8'h04);
        wr(3, 8'h11);
        chk("R4 periodic on rejected", port_test_on[0], 0);
        rd(1, d); chk("R4 error periodic", d, 3);
        wr(1, 2);
        wr(0, 8'h08);
        wr(3, 8'h11);
        chk("R4 async on rejected", port_test_on[0], 0);
        rd(1, d); chk("R4 error async", d, 3);
        wr(1, 2);
        wr(0, 0);
        wr(2, 0);
        wr(3, 8'h11);
        chk("R4 cfg off rejected", port_test_on[0], 0);
        rd(1, d); chk("R4 error cfg", d, 3);
        wr(1, 2);
        wr(2, 1);
        wr(0, 1);
        tick(2);
        wr(3, 8'h11);
        chk("R4 not halted rejected", port_test_on[0], 0);
        rd(1, d); chk("R4 error running", d, 2);
        wr(1, 2);
        wr(0, 0);
        tick(3);
        wr(3, 8'h11);
        chk("R4 accepted", port_test_on[0], 1);
        chk("R4 accepted line J", line(0), 1);
        rd(1, d); chk("R4 no error on accept", d, 1);
        hc_reset();
    endtask

    task automatic t_modes();
        int d;
        for (int c = 1; c <= 3; c++) begin
            arm(0);
            wr(3, 1 | (c << 4));
            chk("R3 line code", line(0), c);
            chk("R3 test_on", port_test_on[0], 1);
            rd(3, d); chk("R3 readback field", d >> 4, c);
            chk("R8 other port idle", port_test_on[1], 0);
            hc_reset();
            chk("R9 idle after reset", line(0), 0);
        end
    endtask

    task automatic t_reserved();
        int d;
        for (int c = 6; c <= 7; c++) begin
            arm(1);
            wr(4, 1 | (c << 4));
            chk("R5 no test", port_test_on[1], 0);
            chk("R5 line idle", line(1), 0);
            rd(4, d); chk("R5 field reads 0, suspend kept", d, 1);
            rd(1, d); chk("R5 no error", d, 1);
            hc_reset();
        end
    endtask

    task automatic t_packet();
        arm(0);
        wr(3, 8'h41);
        chk("R6 strobe first cycle", port_pkt_start[0], 1);
        chk("R3 packet line idle", line(0), 0);
        chk("R6 test_on", port_test_on[0], 1);
        tick(1);
        chk("R6 strobe gone", port_pkt_start[0], 0);
        chk("R6 still in test", port_test_on[0], 1);
        hc_reset();
    endtask

    task automatic t_force();
        arm(1);
        wr(4, 8'h51);
        chk("R7 force, run off", port_sof_en[1], 0);
        chk("R3 force line idle", line(1), 0);
        wr(0, 1);
        chk("R7 force, run on", port_sof_en[1], 1);
        tick(3);
        chk("R8 run does not exit", port_test_on[1], 1);
        wr(0, 0);
        chk("R7 force, run off again", port_sof_en[1], 0);
        tick(3);
        hc_reset();
        arm(0);
        wr(3, 8'h21);
        wr(0, 1);
        chk("R7 K mode, sof off with run", port_sof_en[0], 0);
        wr(0, 0);
        tick(3);
        hc_reset();
    endtask

    task automatic t_lock_exit();
        int d;
        arm(1);
        wr(4, 8'h11);
        wr(4, 8'h21);
        chk("R8 mode kept", line(1), 1);
        wr(4, 0);
        chk("R8 clear ignored", port_test_on[1], 1);
        rd(4, d); chk("R8 suspend and field kept", d, 8'h11);
        rd(1, d); chk("R8 no error", d, 1);
        arm(0);
        wr(3, 8'h31);
        chk("R8 second port SE0", line(0), 3);
        wr(0, 1);
        tick(2);
        wr(0, 8'h03);
        chk("R9 reset ignored when running", line(1), 1);
        chk("R9 run kept", hc_halted, 0);
        wr(0, 0);
        tick(3);
        wr(5, 0);
        wr(3, 0);
        wr(0, 8'h02);
        chk("R9 port1 idle", line(1), 0);
        chk("R9 port0 idle", line(0), 0);
        chk("R9 no test", int'(port_test_on), 0);
        rd(3, d); chk("R9 port0 cleared", d, 0);
        rd(4, d); chk("R9 port1 cleared", d, 0);
        rd(1, d); chk("R9 status", d, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick(1);
        t_reset_state();
        t_halt_and_sof();
        t_reject();
        t_modes();
        t_reserved();
        t_packet();
        t_force();
        t_lock_exit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule